// File: doc/BRIEF.md
# Serial Byte Receiver with Parity Check and Receive Queue

This block turns an asynchronous serial line into bytes. The line passes through a two-flop synchroniser. A falling edge starts a candidate frame. The line is sampled again at half a bit period, and if it is still low the start bit is accepted. After that, each data bit is taken once per bit period, at mid-bit, least significant bit first. A bit period is `div_i + 1` system clocks, and the divisor value is the one the transmitter uses. When parity is enabled, one parity bit follows the data and is checked against the selected sense. The receiver then waits one stop-bit period and goes back to watching for the next start bit.

Each completed byte goes into a 16-entry receive queue. A byte is stored even when its parity check fails. The queue shows its oldest byte on a read port at all times. A pop strobe removes that byte, a flush input empties the queue, and an empty flag reports when no bytes are held. A parity mismatch sets a sticky error flag, which stays set until the clear input is pulsed.

Top module: `uart_rx_pq`

## Requirements
- R1: Each frame is a low start bit followed by 8 data bits sent least significant bit first. Every data bit lasts `div_i + 1` clocks and is sampled at mid-bit. Bytes appear on `rd_data_o` in the order they arrived.
- R2: A falling edge on `rx_i` starts a frame only if the synchronised line is still low `div_i >> 1` clocks later. A shorter low pulse produces no byte.
- R3: `par_mode_i` selects the parity check: 0 means no parity bit, 1 means odd parity (the data ones plus the parity bit give an odd count), and 2 means even parity. A mismatch sets `par_err_o`.
- R4: `par_err_o` is 0 after reset. Once set, it stays 1 until `par_err_clr_i` is high at a clock edge. If a new mismatch and a clear happen in the same cycle, the flag stays set.
- R5: `empty_o` is 1 exactly when the queue holds no bytes, including right after reset.
- R6: `pop_i` removes the oldest byte. A pop while the queue is empty has no effect.
- R7: `flush_i` discards every queued byte. A byte completing in the same cycle is also discarded.
- R8: A byte whose parity check fails is still stored in the queue.
- R9: The queue holds 16 bytes. A byte that completes while 16 bytes are held is dropped, and the held bytes are unchanged.
- R10: After the stop-bit period the receiver looks for a new start bit, so back-to-back frames with no idle time are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idles high |
| div_i | input | 16 | Bit period minus one, in clocks |
| par_mode_i | input | 2 | 0 none, 1 odd, 2 even |
| pop_i | input | 1 | Remove the oldest queued byte |
| flush_i | input | 1 | Empty the queue |
| par_err_clr_i | input | 1 | Clear the sticky parity error |
| rd_data_o | output | 8 | Oldest queued byte |
| empty_o | output | 1 | Queue holds no bytes |
| par_err_o | output | 1 | Sticky parity mismatch flag |

## Verification
The assertions assume that `div_i` is at least 1, that `par_mode_i` never takes the value 3, and that `div_i` and `par_mode_i` do not change while a frame is being received. The stimulus sets these inputs only when the line has been idle long enough for any frame in progress to finish. It drives every frame with exactly `div_i + 1` clocks per bit, and it changes inputs only on the falling clock edge.

// File: rtl/uart_rx_pq_pkg.sv
package uart_rx_pq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam logic [1:0] PM_NONE = 2'd0;
    localparam logic [1:0] PM_ODD  = 2'd1;
    localparam logic [1:0] PM_EVEN = 2'd2;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = line_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], line_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_o = sh_q[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import uart_rx_pq_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [1:0]        par_mode_i,
    input  logic              clr_i,
    output logic              push_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              par_err_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [DIV_W-1:0]  cnt;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] shreg;
        logic              bad;
        logic              push;
        logic [DATA_W-1:0] data;
        logic              sticky;
    } fr_t;

    localparam fr_t FR_RST = '{state: ST_IDLE, cnt: '0, idx: '0, shreg: '0,
                               bad: 1'b0, push: 1'b0, data: '0, sticky: 1'b0};

    fr_t r_q, r_d;
    logic bit_end, half_end, set_err, ones_odd;

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        set_err  = 1'b0;
        bit_end  = (r_q.cnt == div_i);
        half_end = (r_q.cnt == (div_i >> 1));
        ones_odd = (^r_q.shreg) ^ rx_s_i;
        case (r_q.state)
            ST_IDLE: begin
                if (!rx_s_i) begin
                    r_d.state = ST_START;
                    r_d.cnt   = '0;
                end
            end
            ST_START: begin
                if (half_end) begin
                    r_d.cnt = '0;
                    if (!rx_s_i) begin
                        r_d.state = ST_DATA;
                        r_d.idx   = '0;
                        r_d.bad   = 1'b0;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    r_d.cnt   = '0;
                    r_d.shreg = {rx_s_i, r_q.shreg[DATA_W-1:1]};
                    if (r_q.idx == LAST_IDX) begin
                        r_d.state = (par_mode_i == PM_NONE) ? ST_STOP : ST_PAR;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (bit_end) begin
                    r_d.cnt   = '0;
                    r_d.bad   = (par_mode_i == PM_ODD) ? ~ones_odd : ones_odd;
                    r_d.state = ST_STOP;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    r_d.cnt   = '0;
                    r_d.push  = 1'b1;
                    r_d.data  = r_q.shreg;
                    set_err   = r_q.bad;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (set_err)    r_d.sticky = 1'b1;
        else if (clr_i) r_d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= FR_RST;
        else        r_q <= r_d;
    end

    assign push_o    = r_q.push;
    assign byte_o    = r_q.data;
    assign par_err_o = r_q.sticky;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sticky && !clr_i) |=> r_q.sticky); // R4
    AST_PUSH_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ($past(r_q.state) == ST_STOP)); // R10
    AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_DATA) && ($past(r_q.state) == ST_START)) |-> !$past(rx_s_i)); // R2
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [AW-1:0]                wr;
        logic [AW-1:0]                rd;
        logic [CW-1:0]                count;
    } q_t;

    q_t s_q, s_d;
    logic full, do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        full    = (s_q.count == CW'(DEPTH));
        do_push = push_i && !full;
        do_pop  = pop_i && (s_q.count != '0);
        if (flush_i) begin
            s_d.wr    = '0;
            s_d.rd    = '0;
            s_d.count = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = data_i;
                s_d.wr = (s_q.wr == LAST_PTR) ? '0 : s_q.wr + 1'b1;
            end
            if (do_pop) begin
                s_d.rd = (s_q.rd == LAST_PTR) ? '0 : s_q.rd + 1'b1;
            end
            s_d.count = s_q.count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.mem[s_q.rd];
    assign empty_o   = (s_q.count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i && !flush_i) |=> (s_q.count == CW'(DEPTH))); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o); // R7
    AST_POP_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !flush_i) |=> empty_o); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH)); // R9
endmodule

// File: rtl/uart_rx_pq.sv
module uart_rx_pq #(
    parameter int DIV_W   = 16,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [1:0]        par_mode_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic              par_err_clr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              empty_o,
    output logic              par_err_o
);
    logic              rx_s;
    logic              push;
    logic [DATA_W-1:0] rx_byte;

    rx_line_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_i),
        .line_o (rx_s)
    );

    rx_deframer #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_deframe (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_s_i     (rx_s),
        .div_i      (div_i),
        .par_mode_i (par_mode_i),
        .clr_i      (par_err_clr_i),
        .push_o     (push),
        .byte_o     (rx_byte),
        .par_err_o  (par_err_o)
    );

    rx_byte_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .data_i    (rx_byte),
        .pop_i     (pop_i),
        .flush_i   (flush_i),
        .rd_data_o (rd_data_o),
        .empty_o   (empty_o)
    );
endmodule

// File: tb/sim_uart_rx_pq.sv
`timescale 1ns/1ps
module sim_uart_rx_pq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [15:0] div = 16'd7;
    logic [1:0] mode = 2'd0;
    logic       pop = 1'b0, flush = 1'b0, clr = 1'b0;
    logic [7:0] rd_data;
    logic       empty, perr;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_pq u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .div_i(div), .par_mode_i(mode),
        .pop_i(pop), .flush_i(flush), .par_err_clr_i(clr),
        .rd_data_o(rd_data), .empty_o(empty), .par_err_o(perr)
    );

    // behavioural reference: line history, frame progress, byte queue
    int  m_line1, m_line2, m_phase, m_wait, m_bits, m_val, m_bad, m_sticky;
    int  m_hand, m_hand_v;
    byte unsigned m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_line1 = 1; m_line2 = 1; m_phase = 0; m_wait = 0; m_bits = 0;
            m_val = 0; m_bad = 0; m_sticky = 0; m_hand = 0; m_hand_v = 0;
            m_q.delete();
        end else begin
            int set_e;
            int full;
            set_e = 0;
            if (flush) m_q.delete();
            else begin
                full = (m_q.size() >= 16);
                if (pop && m_q.size() > 0) void'(m_q.pop_front());
                if (m_hand != 0 && full == 0) m_q.push_back(8'(m_hand_v));
            end
            m_hand = 0;
            // phase: 0 hunt, 1 confirm, 2 data, 3 parity, 4 stop
            if (m_phase == 0) begin
                if (m_line2 == 0) begin m_phase = 1; m_wait = 0; end
            end else if (m_phase == 1) begin
                if (m_wait == int'(div) / 2) begin
                    m_wait = 0;
                    if (m_line2 == 0) begin m_phase = 2; m_bits = 0; m_bad = 0; end
                    else m_phase = 0;
                end else m_wait++;
            end else begin
                if (m_wait == int'(div)) begin
                    m_wait = 0;
                    if (m_phase == 2) begin
                        m_val = (m_val >> 1) | (m_line2 << 7);
                        m_bits++;
                        if (m_bits == 8) m_phase = (mode == 2'd0) ? 4 : 3;
                    end else if (m_phase == 3) begin
                        int ones;
                        ones = $countones(8'(m_val)) + m_line2;
                        m_bad = (mode == 2'd1) ? ((ones % 2) == 0) : ((ones % 2) == 1);
                        m_phase = 4;
                    end else begin
                        m_hand = 1; m_hand_v = m_val; set_e = m_bad; m_phase = 0;
                    end
                end else m_wait++;
            end
            if (set_e != 0) m_sticky = 1;
            else if (clr) m_sticky = 0;
            m_line2 = m_line1; m_line1 = rx;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (empty !== (m_q.size() == 0)) begin
                errors++;
                $display("FAIL R5 empty_o act=%0b exp=%0b t=%0t", empty, m_q.size() == 0, $time);
            end
            checks++;
            if (perr !== 1'(m_sticky)) begin
                errors++;
                $display("FAIL R3/R4 par_err_o act=%0b exp=%0d t=%0t", perr, m_sticky, $time);
            end
            if (m_q.size() > 0) begin
                checks++;
                if (rd_data !== m_q[0]) begin
                    errors++;
                    $display("FAIL R1 rd_data_o act=%02h exp=%02h t=%0t", rd_data, m_q[0], $time);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input byte unsigned d, input int pm, input bit flip);
        int p;
        p = int'(div) + 1;
        rx = 1'b0; ticks(p);
        for (int i = 0; i < 8; i++) begin rx = d[i]; ticks(p); end
        if (pm != 0) begin
            bit pb;
            pb = (pm == 1) ? ~(^d) : (^d);
            rx = pb ^ flip; ticks(p);
        end
        rx = 1'b1; ticks(p);
    endtask

    task automatic settle();
        ticks(int'(div) + 6);
    endtask

    task automatic pop_exp(input byte unsigned e, input string tag);
        chk(!empty && rd_data == e, tag, rd_data, e);
        pop = 1'b1; ticks(1); pop = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1; ticks(1); flush = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ticks(4);
        rst_n = 1'b1;
        ticks(1);
        cmp_on = 1'b1;
        chk(empty == 1'b1, "R5 empty after reset", empty, 1);
        chk(perr == 1'b0, "R4 par_err after reset", perr, 0);

        // R1 R10: back-to-back frames, no parity
        send(8'hA5, 0, 0);
        send(8'h3C, 0, 0);
        settle();
        pop_exp(8'hA5, "R1 first byte");
        pop_exp(8'h3C, "R10 back-to-back byte");
        chk(empty == 1'b1, "R6 empty after popping all", empty, 1);
        // R6: pop while empty
        pop = 1'b1; ticks(3); pop = 1'b0;
        chk(empty == 1'b1, "R6 pop on empty ignored", empty, 1);

        // R3 odd parity: good then bad; R8 bad byte stored
        mode = 2'd1;
        send(8'h01, 1, 0);
        settle();
        chk(perr == 1'b0, "R3 odd parity correct", perr, 0);
        send(8'h03, 1, 1);
        settle();
        chk(perr == 1'b1, "R3 odd parity mismatch", perr, 1);
        pop_exp(8'h01, "R3 odd good byte");
        pop_exp(8'h03, "R8 bad-parity byte stored");
        ticks(20);
        chk(perr == 1'b1, "R4 flag sticky", perr, 1);
        clr = 1'b1; ticks(1); clr = 1'b0;
        chk(perr == 1'b0, "R4 flag cleared", perr, 0);

        // R3 even parity with another divisor
        mode = 2'd2; div = 16'd10;
        ticks(4);
        send(8'h07, 2, 0);
        settle();
        chk(perr == 1'b0, "R3 even parity correct", perr, 0);
        send(8'h5A, 2, 1);
        settle();
        chk(perr == 1'b1, "R3 even parity mismatch", perr, 1);
        pop_exp(8'h07, "R1 even byte");
        pop_exp(8'h5A, "R8 even bad byte stored");
        clr = 1'b1; ticks(1); clr = 1'b0;

        // R2: short low glitch yields nothing
        mode = 2'd0; div = 16'd7;
        ticks(4);
        rx = 1'b0; ticks(2); rx = 1'b1;
        ticks(40);
        chk(empty == 1'b1, "R2 glitch rejected", empty, 1);
        send(8'hC3, 0, 0);
        settle();
        pop_exp(8'hC3, "R2 frame after glitch");

        // R9: 17 bytes into 16 entries
        for (int k = 0; k < 17; k++) send(8'(k + 8'h10), 0, 0);
        settle();
        for (int k = 0; k < 16; k++) pop_exp(8'(k + 8'h10), "R9 held byte");
        chk(empty == 1'b1, "R9 overflow byte dropped", empty, 1);

        // R7: flush discards
        send(8'h11, 0, 0);
        send(8'h22, 0, 0);
        settle();
        chk(empty == 1'b0, "R7 bytes present before flush", empty, 0);
        pulse_flush();
        chk(empty == 1'b1, "R7 flush empties", empty, 1);
        send(8'h44, 0, 0);
        settle();
        pop_exp(8'h44, "R7 receive after flush");

        ticks(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule